// File: doc/BRIEF.md
# Task and Event Register Block with Channel Triggering

This block is the software-visible control surface of a small hardware engine that has two tasks (start and stop) and three events (done, match found, no match). Software triggers a task by writing a 1, or a task can be wired to one of the chip's hardware trigger channels. The channel vector is sampled every cycle, and the task fires whenever the selected channel bit is high and the task's subscription is enabled.

Each event input from the engine sets a sticky flag. Software can read the flag and clear it. The same event can also be published: a one-cycle strobe goes out together with a configured channel index, for the channel fabric to route. A single interrupt line combines the flags under one set of interrupt enables. Those enables are changed through two registers, one that sets bits and one that clears bits.

Top module: `evtask_regblk`

## Requirements
- R1: After reset every register reads 0, and `task_o`, `pub_stb_o`, `pub_chan_o` and `irq_o` are 0.
- R2: A write with bit 0 set to offset 0x000 (start, `task_o[0]`) or 0x008 (stop, `task_o[1]`) pulses that task for exactly one cycle, in the cycle after the write edge. A write with bit 0 clear produces no pulse. Both offsets read 0.
- R3: The subscribe registers at 0x080 (start) and 0x088 (stop) hold a channel index in bits 7:0 and an enable in bit 31. Both fields read back as written, and all other bits read 0.
- R4: When a task's subscribe enable is 1 and `chan_i[index]` is high at a clock edge, the task pulses in the following cycle. A high level on any other channel, or on the selected channel while the enable is 0, does not trigger the task.
- R5: The event flags are at 0x100, 0x104 and 0x108, fed by `evt_i[0]`, `evt_i[1]` and `evt_i[2]` respectively. An event pulse sets the flag, which reads back in bit 0. A software write loads bit 0 of the write data into the flag. When an event pulse and a write land in the same cycle, the flag ends up set.
- R6: The publish registers at 0x180, 0x184 and 0x188 (events 0, 1 and 2) use the same format as R3. When an event pulses and its publish enable is 1, `pub_stb_o[e]` is high for one cycle in the following cycle. Throughout, `pub_chan_o[8e+7:8e]` carries the configured index.
- R7: Interrupt enables sit at bits 0, 1 and 2 for events 0, 1 and 2. Writing 1s to 0x304 sets the matching enables, and writing 1s to 0x308 clears them. Zero bits in either write leave the enables unchanged. Both offsets read the current enable state.
- R8: `irq_o` is high exactly when at least one event flag is set and its interrupt enable is also set.
- R9: Any offset other than those above reads 0, and writing to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wen | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_i | input | 3 | Event pulses from the engine |
| chan_i | input | 256 | Incoming trigger channel vector |
| task_o | output | 2 | Task pulses: bit 0 start, bit 1 stop |
| pub_stb_o | output | 3 | Publish strobe for each event |
| pub_chan_o | output | 24 | Channel index for each event, 8 bits per event |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an event pulse arriving in the same cycle as a software write that clears that event's flag. This case, together with interleaved writes to the set-enable and clear-enable registers, decides whether the flag, the enables and the interrupt stay consistent. A random phase drives event pulses, enable writes and flag writes in the same cycles, with all of them chosen at random, and follows each result with a reference model. A directed case first forces the collision on its own. Channel triggering is checked at the top index, at an index next to it, and with the subscription disabled.

// File: rtl/evtask_pkg.sv
package evtask_pkg;
   localparam int NUM_TASKS = 2;
   localparam int NUM_EVTS  = 3;
   localparam int TASK_BASE = 'h000;  // stride 8
   localparam int SUB_BASE  = 'h080;  // stride 8
   localparam int EVT_BASE  = 'h100;  // stride 4
   localparam int PUB_BASE  = 'h180;  // stride 4
   localparam int IEN_SET   = 'h304;
   localparam int IEN_CLR   = 'h308;
   localparam int EN_BIT    = 31;
endpackage

// File: rtl/evtask_trig.sv
module evtask_trig #(
   parameter int NCH = 256,
   localparam int CHW = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sw_trig,
   input  logic           cfg_we,
   input  logic [31:0]    cfg_wdata,
   output logic [31:0]    cfg_rdata,
   input  logic [NCH-1:0] chan_i,
   output logic           task_o
);
   logic           en_q;
   logic [CHW-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         idx_q  <= '0;
         task_o <= 1'b0;
      end else begin
         if (cfg_we) begin
            en_q  <= cfg_wdata[evtask_pkg::EN_BIT];
            idx_q <= cfg_wdata[CHW-1:0];
         end
         task_o <= sw_trig | (en_q & chan_i[idx_q]);
      end
   end

   always_comb begin
      cfg_rdata                       = '0;
      cfg_rdata[evtask_pkg::EN_BIT]   = en_q;
      cfg_rdata[CHW-1:0]              = idx_q;
   end

   p_sub_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && chan_i[idx_q]) |=> task_o);
   p_sw_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sw_trig |=> task_o);
endmodule

// File: rtl/evtask_evt.sv
module evtask_evt #(
   parameter int NCH = 256,
   localparam int CHW = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           evt_i,
   input  logic           flag_we,
   input  logic           flag_wbit,
   output logic           flag_o,
   input  logic           pub_we,
   input  logic [31:0]    pub_wdata,
   output logic [31:0]    pub_rdata,
   output logic           pub_stb_o,
   output logic [CHW-1:0] pub_idx_o
);
   logic pub_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o    <= 1'b0;
         pub_en_q  <= 1'b0;
         pub_idx_o <= '0;
         pub_stb_o <= 1'b0;
      end else begin
         if (evt_i)        flag_o <= 1'b1;
         else if (flag_we) flag_o <= flag_wbit;
         if (pub_we) begin
            pub_en_q  <= pub_wdata[evtask_pkg::EN_BIT];
            pub_idx_o <= pub_wdata[CHW-1:0];
         end
         pub_stb_o <= evt_i & pub_en_q;
      end
   end

   always_comb begin
      pub_rdata                     = '0;
      pub_rdata[evtask_pkg::EN_BIT] = pub_en_q;
      pub_rdata[CHW-1:0]            = pub_idx_o;
   end

   p_evt_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> flag_o);
   p_pub_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pub_stb_o |-> $past(evt_i && pub_en_q));
endmodule

// File: rtl/evtask_regblk.sv
module evtask_regblk #(
   parameter int NCH     = 256,
   parameter int AW      = 12,
   parameter bit IRQ_REG = 1'b0,
   localparam int CHW    = $clog2(NCH),
   localparam int NT     = evtask_pkg::NUM_TASKS,
   localparam int NE     = evtask_pkg::NUM_EVTS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    reg_addr,
   input  logic             reg_wen,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic [NE-1:0]    evt_i,
   input  logic [NCH-1:0]   chan_i,
   output logic [NT-1:0]    task_o,
   output logic [NE-1:0]    pub_stb_o,
   output logic [NE*CHW-1:0] pub_chan_o,
   output logic             irq_o
);
   import evtask_pkg::*;

   initial begin
      assert (CHW >= 1 && CHW <= 8) else $error("NCH must be 2..256");
      assert ((1 << CHW) == NCH) else $error("NCH must be a power of two");
      assert (AW >= 12) else $error("AW too narrow for register map");
   end

   logic [NT-1:0] sub_we;
   logic [NT-1:0] sw_trig;
   logic [31:0]   sub_rd [NT];
   logic [NE-1:0] flag_we, pub_we, flag_q;
   logic [31:0]   pub_rd [NE];
   logic [NE-1:0] ien_q;
   logic          set_we, clr_we;
   logic          irq_next;

   assign set_we = reg_wen && (reg_addr == AW'(IEN_SET));
   assign clr_we = reg_wen && (reg_addr == AW'(IEN_CLR));

   for (genvar t = 0; t < NT; t++) begin : g_task
      assign sub_we[t]  = reg_wen && (reg_addr == AW'(SUB_BASE + 8*t));
      assign sw_trig[t] = reg_wen && (reg_addr == AW'(TASK_BASE + 8*t)) && reg_wdata[0];
      evtask_trig #(.NCH(NCH)) u_trig (
         .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig[t]),
         .cfg_we(sub_we[t]), .cfg_wdata(reg_wdata), .cfg_rdata(sub_rd[t]),
         .chan_i(chan_i), .task_o(task_o[t]));
   end

   for (genvar e = 0; e < NE; e++) begin : g_evt
      assign flag_we[e] = reg_wen && (reg_addr == AW'(EVT_BASE + 4*e));
      assign pub_we[e]  = reg_wen && (reg_addr == AW'(PUB_BASE + 4*e));
      evtask_evt #(.NCH(NCH)) u_evt (
         .clk(clk), .rst_n(rst_n), .evt_i(evt_i[e]),
         .flag_we(flag_we[e]), .flag_wbit(reg_wdata[0]), .flag_o(flag_q[e]),
         .pub_we(pub_we[e]), .pub_wdata(reg_wdata), .pub_rdata(pub_rd[e]),
         .pub_stb_o(pub_stb_o[e]), .pub_idx_o(pub_chan_o[e*CHW +: CHW]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien_q <= '0;
      else if (set_we) ien_q <= ien_q | reg_wdata[NE-1:0];
      else if (clr_we) ien_q <= ien_q & ~reg_wdata[NE-1:0];
   end

   assign irq_next = |(flag_q & ien_q);

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= irq_next;
      end
   end else begin : g_irq_comb
      assign irq_o = irq_next;
   end

   always_comb begin
      reg_rdata = '0;
      for (int t = 0; t < NT; t++)
         if (reg_addr == AW'(SUB_BASE + 8*t)) reg_rdata = sub_rd[t];
      for (int e = 0; e < NE; e++) begin
         if (reg_addr == AW'(EVT_BASE + 4*e)) reg_rdata = {31'd0, flag_q[e]};
         if (reg_addr == AW'(PUB_BASE + 4*e)) reg_rdata = pub_rd[e];
      end
      if (reg_addr == AW'(IEN_SET) || reg_addr == AW'(IEN_CLR))
         reg_rdata = {{(32-NE){1'b0}}, ien_q};
   end

   p_ien_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && reg_wdata[0]) |=> ien_q[0]);
   p_ien_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && reg_wdata[0]) |=> !ien_q[0]);
   p_ien_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(ien_q));
   p_pub_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(|evt_i) |=> (pub_stb_o == '0));
endmodule

// File: tb/sim_evtask_regblk.sv
module sim_evtask_regblk;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [11:0]  reg_addr = '0;
   logic         reg_wen = 1'b0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic [2:0]   evt_i = '0;
   logic [255:0] chan_i = '0;
   logic [1:0]   task_o;
   logic [2:0]   pub_stb_o;
   logic [23:0]  pub_chan_o;
   logic         irq_o;

   int errors = 0;
   int checks = 0;
   logic [2:0] m_flag = '0;
   logic [2:0] m_ien  = '0;

   always #2 clk = ~clk;

   evtask_regblk u0 (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at negedge, hold through one posedge, return 1 ns after it
   task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic [2:0] ev, input logic [255:0] ch);
      @(negedge clk);
      reg_wen = we; reg_addr = a; reg_wdata = d; evt_i = ev; chan_i = ch;
      @(posedge clk); #1;
      reg_wen = 1'b0; evt_i = '0; chan_i = '0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a; #0.5; d = reg_rdata;
   endtask

   function automatic logic exp_irq(input logic [2:0] f, input logic [2:0] en);
      return |(f & en);
   endfunction

   initial begin
      #800000;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd4242));
      #1;
      chk("R1 task_o", {30'd0, task_o}, 0);
      chk("R1 irq", {31'd0, irq_o}, 0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      rd(12'h080, v); chk("R1 sub reset", v, 0);
      rd(12'h184, v); chk("R1 pub reset", v, 0);
      rd(12'h304, v); chk("R1 ien reset", v, 0);
      chk("R1 pub_chan", {8'd0, pub_chan_o}, 0);

      // R2 software triggers
      cyc(1, 12'h000, 32'h1, 0, 0); chk("R2 start pulse", {30'd0, task_o}, 2'b01);
      @(posedge clk); #1;           chk("R2 single cycle", {30'd0, task_o}, 0);
      cyc(1, 12'h008, 32'h3, 0, 0); chk("R2 stop pulse", {30'd0, task_o}, 2'b10);
      cyc(1, 12'h000, 32'h2, 0, 0); chk("R2 bit0 clear no pulse", {30'd0, task_o}, 0);
      rd(12'h000, v); chk("R2 write-only read", v, 0);

      // R3 subscribe format
      cyc(1, 12'h080, 32'hFFFF_FFFF, 0, 0);
      rd(12'h080, v); chk("R3 sub mask", v, 32'h8000_00FF);
      cyc(1, 12'h088, 32'h8000_0005, 0, 0);
      rd(12'h088, v); chk("R3 sub readback", v, 32'h8000_0005);

      // R4 channel triggering
      cyc(0, 0, 0, 0, 256'd1 << 255); chk("R4 top channel", {30'd0, task_o}, 2'b01);
      cyc(0, 0, 0, 0, 256'd1 << 254); chk("R4 neighbour channel", {30'd0, task_o}, 0);
      cyc(0, 0, 0, 0, 256'd1 << 5);   chk("R4 stop channel", {30'd0, task_o}, 2'b10);
      cyc(1, 12'h088, 32'h0000_0005, 0, 0);
      cyc(0, 0, 0, 0, 256'd1 << 5);   chk("R4 disabled", {30'd0, task_o}, 0);

      // R6 publish
      cyc(1, 12'h184, 32'h8000_0022, 0, 0);
      rd(12'h184, v); chk("R6 pub readback", v, 32'h8000_0022);
      chk("R6 pub index", {24'd0, pub_chan_o[15:8]}, 32'h22);
      cyc(0, 0, 0, 3'b010, 0); chk("R6 strobe", {29'd0, pub_stb_o}, 3'b010);
      m_flag[1] = 1'b1;
      @(posedge clk); #1;      chk("R6 strobe ends", {29'd0, pub_stb_o}, 0);
      cyc(0, 0, 0, 3'b001, 0); chk("R6 no publish when disabled", {29'd0, pub_stb_o}, 0);
      m_flag[0] = 1'b1;

      // R5 flags, collision
      rd(12'h104, v); chk("R5 flag set", v, 1);
      cyc(1, 12'h104, 32'h0, 0, 0); m_flag[1] = 1'b0;
      rd(12'h104, v); chk("R5 sw clear", v, 0);
      cyc(1, 12'h100, 32'h0, 3'b001, 0);
      rd(12'h100, v); chk("R5 event wins over clear", v, 1);

      // R7/R8 directed
      cyc(1, 12'h304, 32'h4, 0, 0); m_ien = 3'b100;
      chk("R8 irq masked", {31'd0, irq_o}, 0);
      cyc(1, 12'h304, 32'h0, 0, 0);
      rd(12'h308, v); chk("R7 zero write no effect", v, 32'h4);
      cyc(1, 12'h304, 32'h1, 0, 0); m_ien = 3'b101;
      chk("R8 irq on", {31'd0, irq_o}, 1);

      // R9 unmapped
      cyc(1, 12'h30C, 32'hFFFF_FFFF, 0, 0);
      rd(12'h30C, v); chk("R9 unmapped read", v, 0);
      rd(12'h304, v); chk("R9 no side effect", v, {29'd0, m_ien});

      // random mix of events, enable and flag writes
      for (int i = 0; i < 400; i++) begin
         logic [2:0] ev;
         int op;
         logic [31:0] d;
         logic [11:0] a;
         int e;
         ev = 3'($urandom % 8) & 3'($urandom % 8);
         op = $urandom % 4;
         d  = $urandom;
         e  = $urandom % 3;
         a  = (op == 1) ? 12'h304 : (op == 2) ? 12'h308 : 12'(12'h100 + 4*e);
         cyc(op != 0, a, d, ev, 0);
         if (op == 1) m_ien = m_ien | d[2:0];
         else if (op == 2) m_ien = m_ien & ~d[2:0];
         else if (op == 3) m_flag[e] = d[0];
         m_flag = m_flag | ev;
         chk("R8 irq random", {31'd0, irq_o}, {31'd0, exp_irq(m_flag, m_ien)});
         rd(12'h304, v); chk("R7 ien random", v, {29'd0, m_ien});
         rd(12'h100 + 12'(4*e), v); chk("R5 flag random", v, {31'd0, m_flag[e]});
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule